// File: doc/BRIEF.md
# Demodulator Mixer Lookup Generator

This block supplies sine and cosine multiplier values to a bank of digital demodulator channels. Each channel owns one page of an on-chip table. A page holds 2^ENT_W time steps, and each step is a pair of signed 8-bit values: sine in the low byte and cosine in the high byte. The page for channel n is page n+1. Page 0 belongs to a different table elsewhere and is never decoded here. Table entries are half a clock apart, so every clock each enabled channel presents two consecutive sample lanes, lane A and lane B.

Software sets up a channel in two steps. It loads the channel's page through a byte-wide table write port. It then programs a 16-bit phase step and a 16-bit start phase through a byte-wide configuration port. While the channel's window input is high, a 16-bit phase accumulator walks the table. Its low ENT_W bits select the entry, so the walk wraps at the end of the page. Each sample advances the phase by the step, which means two steps per clock. A channel whose window is low drives zeros.

Top module: `demix_lut_gen`

## Requirements
- R1: One clock edge after reset is released, all lane outputs are zero. Every channel's step and start phase reset to 0, so a channel enabled before any configuration outputs entry 0 on both lanes.
- R2: A table write with page p in 1..NUM_CH and byte offset k stores the byte in entry k>>1 of channel p-1. It goes to the sine byte when k[0]=0 and to the cosine byte when k[0]=1.
- R3: Table writes to page 0, or to any page above NUM_CH, change no channel's table.
- R4: A configuration write to byte address 4n+b with n < NUM_CH sets one byte of channel n. b=0 is the step low byte, b=1 the step high byte, b=2 the start low byte and b=3 the start high byte. Writes to addresses at or above 4*NUM_CH change nothing.
- R5: On the first clock edge at which a channel's window is sampled high after being low, the lane outputs register entry start mod 2^ENT_W on lane A and entry (start+step) mod 2^ENT_W on lane B. These values are visible during the following cycle.
- R6: On each further edge with the window held high, both lane indices advance by 2*step, computed modulo 2^16 and then taken modulo 2^ENT_W.
- R7: At an edge where a channel's window is sampled low, that channel's four lane outputs become zero. The next rising window restarts from the start phase.
- R8: Channels run independently: one channel's window, step and start have no effect on another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table byte write strobe |
| tbl_page | input | $clog2(NUM_CH+1) | Page select; page n+1 is channel n |
| tbl_offset | input | ENT_W+1 | Byte offset in page; bit 0 selects sine (0) or cosine (1) |
| tbl_wdata | input | VAL_W | Table byte data |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | $clog2(NUM_CH)+2 | Configuration byte address, 4 bytes per channel |
| cfg_wdata | input | 8 | Configuration byte data |
| win_en | input | NUM_CH | Per-channel enable window |
| sin_a | output | NUM_CH*VAL_W | Lane A sine value per channel, channel c at bits [c*VAL_W +: VAL_W] |
| cos_a | output | NUM_CH*VAL_W | Lane A cosine value per channel |
| sin_b | output | NUM_CH*VAL_W | Lane B sine value per channel |
| cos_b | output | NUM_CH*VAL_W | Lane B cosine value per channel |

## Verification
The bench builds the block with NUM_CH=3 and ENT_W=5. With these values a page holds 32 entries, so a walk with a step of 1 wraps the page within 16 clocks and large or negative steps alias through the index many times in a short run. With three channels the configuration address space has four unused addresses (12 to 15) and the page field has no unused values except page 0. Writes to those addresses and to page 0 are driven and then observed through the channel outputs.

// File: rtl/demix_pkg.sv
// Package: shared constants and types for the demodulator mixer lookup generator.
// Assumes four configuration bytes per channel in the order given by cfg_byte_e.
package demix_pkg;

    localparam int CFG_BYTES_PER_CH = 4;

    // Byte position within one channel's configuration group.
    typedef enum logic [1:0] {
        CFG_STEP_LO  = 2'd0,
        CFG_STEP_HI  = 2'd1,
        CFG_START_LO = 2'd2,
        CFG_START_HI = 2'd3
    } cfg_byte_e;

endpackage

// File: rtl/demix_cfg.sv
// Module: per-channel step and start phase registers written one byte at a time.
// Assumes a byte address of {channel, byte position}; out-of-range channels are dropped.
module demix_cfg #(
    parameter int NUM_CH = 4,
    parameter int PH_W   = 16,
    parameter int CFG_AW = $clog2(NUM_CH) + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [7:0]               cfg_wdata,
    output logic [NUM_CH*PH_W-1:0]   step_all,
    output logic [NUM_CH*PH_W-1:0]   start_all
);
    import demix_pkg::*;

    localparam int GRP_W = CFG_AW - 2;

    logic [GRP_W-1:0] grp;
    cfg_byte_e        bsel;

    // Split the byte address into channel group and byte position.
    always_comb begin
        grp  = cfg_addr[CFG_AW-1:2];
        bsel = cfg_byte_e'(cfg_addr[1:0]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [PH_W-1:0] step_q;
        logic [PH_W-1:0] start_q;

        // Update the addressed byte of this channel's step or start phase.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                step_q  <= '0;
                start_q <= '0;
            end else if (cfg_we && (grp == GRP_W'(c))) begin
                case (bsel)
                    CFG_STEP_LO:  step_q[7:0]       <= cfg_wdata;
                    CFG_STEP_HI:  step_q[15:8]      <= cfg_wdata;
                    CFG_START_LO: start_q[7:0]      <= cfg_wdata;
                    default:      start_q[15:8]     <= cfg_wdata;
                endcase
            end
        end

        assign step_all[c*PH_W +: PH_W]  = step_q;
        assign start_all[c*PH_W +: PH_W] = start_q;
    end

endmodule

// File: rtl/demix_phase.sv
// Module: one channel's phase accumulator producing two table indices per clock.
// Assumes the table depth is a power of two no larger than 2^PH_W, so low bits wrap.
module demix_phase #(
    parameter int PH_W  = 16,
    parameter int ENT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PH_W-1:0]  step,
    input  logic [PH_W-1:0]  start,
    output logic [ENT_W-1:0] idx_a,
    output logic [ENT_W-1:0] idx_b,
    output logic [PH_W-1:0]  acc
);
    logic            en_q;
    logic [PH_W-1:0] base;

    // Pick the phase of lane A: reload on a rising window, else continue.
    always_comb begin
        base  = (en && !en_q) ? start : acc;
        idx_a = base[ENT_W-1:0];
        idx_b = base[ENT_W-1:0] + step[ENT_W-1:0];
    end

    // Advance the accumulator by two samples per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= en;
            if (en) begin
                acc <= base + (step << 1);
            end
        end
    end

endmodule

// File: rtl/demix_table.sv
// Module: per-channel sine/cosine pages with byte write and two registered read lanes.
// Assumes page c+1 maps to channel c; other pages are ignored. Outputs zero when disabled.
module demix_table #(
    parameter int NUM_CH = 4,
    parameter int ENT_W  = 9,
    parameter int VAL_W  = 8,
    parameter int PAGE_W = $clog2(NUM_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tbl_we,
    input  logic [PAGE_W-1:0]        tbl_page,
    input  logic [ENT_W:0]           tbl_offset,
    input  logic [VAL_W-1:0]         tbl_wdata,
    input  logic [NUM_CH-1:0]        en,
    input  logic [NUM_CH*ENT_W-1:0]  idx_a_all,
    input  logic [NUM_CH*ENT_W-1:0]  idx_b_all,
    output logic [NUM_CH*VAL_W-1:0]  sin_a,
    output logic [NUM_CH*VAL_W-1:0]  cos_a,
    output logic [NUM_CH*VAL_W-1:0]  sin_b,
    output logic [NUM_CH*VAL_W-1:0]  cos_b
);
    localparam int ENTRIES = 1 << ENT_W;
    localparam int PAIR_W  = 2 * VAL_W;

    logic [ENT_W-1:0] wr_entry;
    logic             wr_hi;

    // Split the byte offset into entry number and sine/cosine select.
    always_comb begin
        wr_entry = tbl_offset[ENT_W:1];
        wr_hi    = tbl_offset[0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [PAIR_W-1:0] mem [ENTRIES];
        logic [PAIR_W-1:0] rd_a;
        logic [PAIR_W-1:0] rd_b;
        logic [VAL_W-1:0]  sa_q, ca_q, sb_q, cb_q;
        logic              pg_hit;

        assign pg_hit = tbl_we && (tbl_page == PAGE_W'(c + 1));

        // Store a written byte into the sine or cosine half of one entry.
        always_ff @(posedge clk) begin
            if (pg_hit) begin
                if (wr_hi) begin
                    mem[wr_entry][PAIR_W-1:VAL_W] <= tbl_wdata;
                end else begin
                    mem[wr_entry][VAL_W-1:0] <= tbl_wdata;
                end
            end
        end

        // Read both lanes' entries for this channel.
        always_comb begin
            rd_a = mem[idx_a_all[c*ENT_W +: ENT_W]];
            rd_b = mem[idx_b_all[c*ENT_W +: ENT_W]];
        end

        // Register lane values, forcing zero while the window is low.
        always_ff @(posedge clk) begin
            if (!rst_n || !en[c]) begin
                sa_q <= '0;
                ca_q <= '0;
                sb_q <= '0;
                cb_q <= '0;
            end else begin
                sa_q <= rd_a[VAL_W-1:0];
                ca_q <= rd_a[PAIR_W-1:VAL_W];
                sb_q <= rd_b[VAL_W-1:0];
                cb_q <= rd_b[PAIR_W-1:VAL_W];
            end
        end

        assign sin_a[c*VAL_W +: VAL_W] = sa_q;
        assign cos_a[c*VAL_W +: VAL_W] = ca_q;
        assign sin_b[c*VAL_W +: VAL_W] = sb_q;
        assign cos_b[c*VAL_W +: VAL_W] = cb_q;
    end

endmodule

// File: rtl/demix_lut_gen.sv
// Module: top of the demodulator mixer lookup generator.
// Ties the configuration registers, one phase accumulator per channel and the tables together.
// Assumes NUM_CH >= 2 and ENT_W <= PH_W.
module demix_lut_gen #(
    parameter int NUM_CH = 4,
    parameter int ENT_W  = 9,
    parameter int VAL_W  = 8,
    parameter int PH_W   = 16,
    localparam int PAGE_W = $clog2(NUM_CH + 1),
    localparam int CFG_AW = $clog2(NUM_CH) + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tbl_we,
    input  logic [PAGE_W-1:0]        tbl_page,
    input  logic [ENT_W:0]           tbl_offset,
    input  logic [VAL_W-1:0]         tbl_wdata,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [7:0]               cfg_wdata,
    input  logic [NUM_CH-1:0]        win_en,
    output logic [NUM_CH*VAL_W-1:0]  sin_a,
    output logic [NUM_CH*VAL_W-1:0]  cos_a,
    output logic [NUM_CH*VAL_W-1:0]  sin_b,
    output logic [NUM_CH*VAL_W-1:0]  cos_b
);
    logic [NUM_CH*PH_W-1:0]  step_all;
    logic [NUM_CH*PH_W-1:0]  start_all;
    logic [NUM_CH*PH_W-1:0]  acc_all;
    logic [NUM_CH*ENT_W-1:0] idx_a_all;
    logic [NUM_CH*ENT_W-1:0] idx_b_all;

    demix_cfg #(
        .NUM_CH (NUM_CH),
        .PH_W   (PH_W),
        .CFG_AW (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .step_all  (step_all),
        .start_all (start_all)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ph
        demix_phase #(
            .PH_W  (PH_W),
            .ENT_W (ENT_W)
        ) u_phase (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (win_en[c]),
            .step  (step_all[c*PH_W +: PH_W]),
            .start (start_all[c*PH_W +: PH_W]),
            .idx_a (idx_a_all[c*ENT_W +: ENT_W]),
            .idx_b (idx_b_all[c*ENT_W +: ENT_W]),
            .acc   (acc_all[c*PH_W +: PH_W])
        );
    end

    demix_table #(
        .NUM_CH (NUM_CH),
        .ENT_W  (ENT_W),
        .VAL_W  (VAL_W),
        .PAGE_W (PAGE_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_we     (tbl_we),
        .tbl_page   (tbl_page),
        .tbl_offset (tbl_offset),
        .tbl_wdata  (tbl_wdata),
        .en         (win_en),
        .idx_a_all  (idx_a_all),
        .idx_b_all  (idx_b_all),
        .sin_a      (sin_a),
        .cos_a      (cos_a),
        .sin_b      (sin_b),
        .cos_b      (cos_b)
    );

endmodule

// File: rtl/demix_lut_gen_chk.sv
// Module: assertion checker for the demodulator mixer lookup generator, bound to the top.
// Assumes the top's internal step, start and accumulator buses are visible to the bind.
module demix_lut_gen_chk #(
    parameter int NUM_CH = 4,
    parameter int VAL_W  = 8,
    parameter int PH_W   = 16,
    parameter int CFG_AW = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [CFG_AW-1:0]        cfg_addr,
    input logic [NUM_CH-1:0]        win_en,
    input logic [NUM_CH*VAL_W-1:0]  sin_a,
    input logic [NUM_CH*VAL_W-1:0]  cos_a,
    input logic [NUM_CH*VAL_W-1:0]  sin_b,
    input logic [NUM_CH*VAL_W-1:0]  cos_b,
    input logic [NUM_CH*PH_W-1:0]   step_all,
    input logic [NUM_CH*PH_W-1:0]   start_all,
    input logic [NUM_CH*PH_W-1:0]   acc_all
);
    localparam int CFG_LIMIT = 4 * NUM_CH;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sin_a == '0 && cos_a == '0 && sin_b == '0 && cos_b == '0));

    // R4
    cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_addr) >= CFG_LIMIT)) |=> ($stable(step_all) && $stable(start_all)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R7
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !win_en[c] |=> (sin_a[c*VAL_W +: VAL_W] == '0 && cos_a[c*VAL_W +: VAL_W] == '0 &&
                            sin_b[c*VAL_W +: VAL_W] == '0 && cos_b[c*VAL_W +: VAL_W] == '0));

        // R5
        reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(win_en[c]) |=> (acc_all[c*PH_W +: PH_W] ==
                PH_W'($past(start_all[c*PH_W +: PH_W]) + 2 * $past(step_all[c*PH_W +: PH_W]))));
    end

endmodule

bind demix_lut_gen demix_lut_gen_chk #(
    .NUM_CH (NUM_CH),
    .VAL_W  (VAL_W),
    .PH_W   (PH_W),
    .CFG_AW (CFG_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .win_en    (win_en),
    .sin_a     (sin_a),
    .cos_a     (cos_a),
    .sin_b     (sin_b),
    .cos_b     (cos_b),
    .step_all  (step_all),
    .start_all (start_all),
    .acc_all   (acc_all)
);

// File: tb/demix_lut_gen_tb.sv
// Bench: seeded random tables, phases and window patterns plus directed corner cases.
module demix_lut_gen_tb;
    localparam int NCH = 3;
    localparam int EW  = 5;
    localparam int VW  = 8;
    localparam int PW  = 16;
    localparam int ENT = 1 << EW;
    localparam int PGW = $clog2(NCH + 1);
    localparam int CAW = $clog2(NCH) + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tbl_we = 1'b0;
    logic [PGW-1:0]   tbl_page = '0;
    logic [EW:0]      tbl_offset = '0;
    logic [VW-1:0]    tbl_wdata = '0;
    logic             cfg_we = 1'b0;
    logic [CAW-1:0]   cfg_addr = '0;
    logic [7:0]       cfg_wdata = '0;
    logic [NCH-1:0]   win_en = '0;
    logic [NCH*VW-1:0] sin_a, cos_a, sin_b, cos_b;

    demix_lut_gen #(.NUM_CH(NCH), .ENT_W(EW), .VAL_W(VW), .PH_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_page(tbl_page),
        .tbl_offset(tbl_offset), .tbl_wdata(tbl_wdata), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .win_en(win_en),
        .sin_a(sin_a), .cos_a(cos_a), .sin_b(sin_b), .cos_b(cos_b)
    );

    always #2 clk = ~clk;

    logic [VW-1:0] m_sin [NCH][ENT];
    logic [VW-1:0] m_cos [NCH][ENT];
    logic [PW-1:0] m_step [NCH];
    logic [PW-1:0] m_start [NCH];
    logic [PW-1:0] m_acc [NCH];
    logic          m_en_q [NCH];
    int            vectors = 0;
    int            errs = 0;
    bit            done = 1'b0;
    string         tag = "";

    function automatic void chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endfunction

    function automatic logic [EW-1:0] idx_of(logic [PW-1:0] ph);
        return ph[EW-1:0];
    endfunction

    task automatic tbl_write(int page, int off, logic [VW-1:0] d);
        @(negedge clk);
        win_en = '0;
        tbl_we = 1'b1; tbl_page = PGW'(page); tbl_offset = (EW+1)'(off); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
        for (int c = 0; c < NCH; c++) m_en_q[c] = 1'b0;
        if (page >= 1 && page <= NCH) begin
            if (off % 2 == 1) m_cos[page-1][off/2] = d;
            else              m_sin[page-1][off/2] = d;
        end
    endtask

    task automatic cfg_write(int addr, logic [7:0] d);
        @(negedge clk);
        win_en = '0;
        cfg_we = 1'b1; cfg_addr = CAW'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int c = 0; c < NCH; c++) m_en_q[c] = 1'b0;
        if (addr < 4 * NCH) begin
            case (addr % 4)
                0: m_step[addr/4][7:0]   = d;
                1: m_step[addr/4][15:8]  = d;
                2: m_start[addr/4][7:0]  = d;
                default: m_start[addr/4][15:8] = d;
            endcase
        end
    endtask

    task automatic set_chan(int ch, logic [PW-1:0] step, logic [PW-1:0] start);
        cfg_write(ch*4 + 0, step[7:0]);
        cfg_write(ch*4 + 1, step[15:8]);
        cfg_write(ch*4 + 2, start[7:0]);
        cfg_write(ch*4 + 3, start[15:8]);
    endtask

    // Drive one window pattern for one edge and compare all lanes afterwards.
    task automatic cycle(logic [NCH-1:0] en);
        logic [VW-1:0] e_sa [NCH];
        logic [VW-1:0] e_ca [NCH];
        logic [VW-1:0] e_sb [NCH];
        logic [VW-1:0] e_cb [NCH];
        string         rq [NCH];
        win_en = en;
        for (int c = 0; c < NCH; c++) begin
            if (en[c]) begin
                logic [PW-1:0] base;
                rq[c] = m_en_q[c] ? "R6" : "R5";
                base = m_en_q[c] ? m_acc[c] : m_start[c];
                e_sa[c] = m_sin[c][idx_of(base)];
                e_ca[c] = m_cos[c][idx_of(base)];
                e_sb[c] = m_sin[c][idx_of(base + m_step[c])];
                e_cb[c] = m_cos[c][idx_of(base + m_step[c])];
                m_acc[c] = base + (m_step[c] << 1);
            end else begin
                rq[c] = "R7";
                e_sa[c] = '0; e_ca[c] = '0; e_sb[c] = '0; e_cb[c] = '0;
            end
            m_en_q[c] = en[c];
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            string r;
            r = $sformatf("%s%s ch%0d", rq[c], tag, c);
            chk({r, " sin_a"}, sin_a[c*VW +: VW], e_sa[c]);
            chk({r, " cos_a"}, cos_a[c*VW +: VW], e_ca[c]);
            chk({r, " sin_b"}, sin_b[c*VW +: VW], e_sb[c]);
            chk({r, " cos_b"}, cos_b[c*VW +: VW], e_cb[c]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int c = 0; c < NCH; c++) begin
            m_step[c] = '0; m_start[c] = '0; m_acc[c] = '0; m_en_q[c] = 1'b0;
            for (int e = 0; e < ENT; e++) begin
                m_sin[c][e] = '0; m_cos[c][e] = '0;
            end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs zero after reset
        for (int c = 0; c < NCH; c++) begin
            chk("R1 reset sin_a", sin_a[c*VW +: VW], '0);
            chk("R1 reset cos_b", cos_b[c*VW +: VW], '0);
        end

        // R2: fill every channel page with random bytes
        for (int p = 1; p <= NCH; p++)
            for (int k = 0; k < 2 * ENT; k++)
                tbl_write(p, k, VW'($urandom));

        // R1: unconfigured channels read entry 0 on both lanes
        tag = " R1";
        cycle('1);
        cycle('1);
        cycle('0);

        // R3: page 0 writes must leave every table unchanged
        for (int i = 0; i < 24; i++) tbl_write(0, $urandom % (2 * ENT), VW'($urandom));
        tag = " R3 R2";
        for (int c = 0; c < NCH; c++) begin
            set_chan(c, 16'd1, 16'd0);
            for (int i = 0; i < ENT / 2 + 3; i++) cycle(NCH'(1 << c));
            cycle('0);
        end

        // R4: writes above the configuration range are dropped
        for (int a = 4 * NCH; a < (1 << CAW); a++) cfg_write(a, 8'($urandom));
        tag = " R4";
        for (int i = 0; i < 6; i++) cycle('1);
        cycle('0);

        // R6: directed wrap corners: negative step, near-top start, half-range step
        tag = " R6";
        set_chan(0, 16'hFFFF, 16'hFFF0);
        set_chan(1, 16'h8000, 16'h0003);
        set_chan(2, 16'h0011, 16'hFFFE);
        for (int i = 0; i < 20; i++) cycle('1);
        cycle('0);

        // R7: toggled window restarts from start phase
        tag = " R7";
        cycle(3'b001); cycle(3'b001); cycle(3'b000); cycle(3'b001); cycle(3'b001);
        cycle('0);

        // R8: random phases and independent random window patterns
        tag = " R8";
        for (int r = 0; r < 40; r++) begin
            for (int c = 0; c < NCH; c++) begin
                logic [PW-1:0] st;
                st = ($urandom % 2 == 0) ? PW'($urandom % 5) : PW'($urandom);
                set_chan(c, st, PW'($urandom));
            end
            for (int i = 0; i < 25; i++) cycle(NCH'($urandom));
            cycle('0);
        end

        // R2: rewrite single sine and cosine bytes, then sweep channel 1
        tbl_write(2, 7, 8'h80);
        tbl_write(2, 6, 8'h7F);
        tag = " R2";
        set_chan(1, 16'd1, 16'd3);
        for (int i = 0; i < 4; i++) cycle(3'b010);
        cycle('0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule